// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block collects thirteen event conditions from a serial peripheral's datapath and turns them into one interrupt line. Each event input is a live level. A rising edge on a level sets a sticky pending bit. Pending bits latch whether or not the event is masked. Software removes a pending bit by writing a one to it in the pending register. The interrupt output is high whenever any pending bit is also enabled in the mask.

The mask is never written directly. One write-only register turns mask bits on, a second write-only register turns them off, and a third register only reads the mask back. A further read-only view shows the live state of four conditions (receive trigger, receive empty, transmit empty, transmit full) without regard to the mask or to the pending bits. Reads are combinational from the read address. Writes take effect at the next rising clock edge.

Top module: `sc_irq_mask_ctrl`

## Requirements
- R1: A write to word 0 (enable) sets every mask bit whose write-data bit is 1 and leaves the other mask bits as they were. Write-data bits 13 and above are ignored.
- R2: A write to word 1 (disable) clears every mask bit whose write-data bit is 1 and leaves the other mask bits as they were.
- R3: Words 0 and 1 always read as zero. Word 2 returns the mask, and a write to word 2 leaves the mask unchanged.
- R4: A 0-to-1 change on any of the 13 event inputs sets the matching bit of the pending register (word 3), whether or not that bit is masked. The event bits are: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout, and 9 to 12 spare.
- R5: A write to word 3 clears each pending bit whose write-data bit is 1. Zero bits leave the pending bits as they were.
- R6: A rising event in the same clock cycle as a clear of that same pending bit leaves the bit set.
- R7: The interrupt output equals the OR over all bits of the pending register ANDed with the mask. It changes in the same cycle as those registers.
- R8: Word 4 returns the live event levels of bits 0, 1, 3 and 4, with every other bit zero, whatever the mask and pending state.
- R9: Reset clears the mask and the pending register, and drives the interrupt output low.
- R10: An event input held high sets its pending bit only once. After that bit is cleared, it stays clear until the input falls and rises again.
- R11: Words 5 to 7 read as zero, and writes to them change neither the mask nor the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word index of the combinational read |
| rd_data | output | 32 | Read data |
| evt_lvl | input | 13 | Live event condition levels from the datapath |
| irq | output | 1 | Interrupt request |

## Verification
A read depends only on the current state, so the bench sets the read address at the falling edge and samples one nanosecond later. A write or an event level changes the mask or the pending bits at the next rising edge. The bench therefore drives these at a falling edge and checks them at the falling edge after that. The interrupt output comes straight from the registered state, so it is checked in the same half-cycle as the pending register. The random phase runs a reference model that updates on each rising edge from the same sampled inputs, and the design is compared against it every cycle.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
  localparam int unsigned EVT_BITS  = 13;
  localparam int unsigned BUS_BITS  = 32;
  localparam int unsigned WORD_BITS = 3;

  localparam int unsigned WORD_ENABLE  = 0;
  localparam int unsigned WORD_DISABLE = 1;
  localparam int unsigned WORD_MASK    = 2;
  localparam int unsigned WORD_PENDING = 3;
  localparam int unsigned WORD_LIVE    = 4;

  // live-view selection: rx trigger, rx empty, tx empty, tx full
  localparam logic [EVT_BITS-1:0] LIVE_SEL = 13'h001B;

  function automatic logic [EVT_BITS-1:0] live_view(input logic [EVT_BITS-1:0] lvl);
    return lvl & LIVE_SEL;
  endfunction

  function automatic logic any_enabled(input logic [EVT_BITS-1:0] pend,
                                       input logic [EVT_BITS-1:0] msk);
    return |(pend & msk);
  endfunction
endpackage

// File: rtl/sc_irq_edge_detect.sv
module sc_irq_edge_detect #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/sc_irq_mask_reg.sv
module sc_irq_mask_reg #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb mask_d = (mask_q | set_bits) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask = mask_q;

  assert_enable_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_bits & ~clr_bits)) |=> ((mask & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) |=> ((mask & $past(clr_bits)) == '0));

  assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask));
endmodule

// File: rtl/sc_irq_pending_reg.sv
module sc_irq_pending_reg #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  // a new rising event outranks a simultaneous software clear
  always_comb pend_d = (pend_q & ~clr_bits) | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  assert_rise_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_bits & ~rise)) |=> ((pend & $past(clr_bits & ~rise)) == '0));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(rise)) == '0));
endmodule

// File: rtl/sc_irq_mask_ctrl.sv
module sc_irq_mask_ctrl
  import sc_irq_pkg::*;
#(
  parameter int unsigned EVT_W  = EVT_BITS,
  parameter int unsigned DATA_W = BUS_BITS,
  parameter int unsigned ADDR_W = WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [EVT_W-1:0]  evt_lvl,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(WORD_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(WORD_DISABLE);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(WORD_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(WORD_PENDING);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(WORD_LIVE);

  logic [EVT_W-1:0] wr_field;
  logic             unused_hi;
  logic             hit_en, hit_dis, hit_pend;
  logic [EVT_W-1:0] mask_set, mask_clr, pend_clr;
  logic [EVT_W-1:0] evt_rise;
  logic [EVT_W-1:0] mask_w, pend_w;

  assign wr_field  = wr_data[EVT_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:EVT_W];

  assign hit_en   = wr_en && (wr_addr == A_EN);
  assign hit_dis  = wr_en && (wr_addr == A_DIS);
  assign hit_pend = wr_en && (wr_addr == A_PEND);

  assign mask_set = hit_en   ? wr_field : '0;
  assign mask_clr = hit_dis  ? wr_field : '0;
  assign pend_clr = hit_pend ? wr_field : '0;

  sc_irq_edge_detect #(.W(EVT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(evt_lvl), .rise(evt_rise)
  );

  sc_irq_mask_reg #(.W(EVT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_bits(mask_set), .clr_bits(mask_clr), .mask(mask_w)
  );

  sc_irq_pending_reg #(.W(EVT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise(evt_rise), .clr_bits(pend_clr), .pend(pend_w)
  );

  always_comb begin
    unique case (rd_addr)
      A_MSK:   rd_data = DATA_W'(mask_w);
      A_PEND:  rd_data = DATA_W'(pend_w);
      A_LIVE:  rd_data = DATA_W'(live_view(evt_lvl));
      default: rd_data = '0;
    endcase
  end

  assign irq = any_enabled(pend_w, mask_w);

  assert_irq_needs_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_w & mask_w) != '0));

  assert_wo_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_EN || rd_addr == A_DIS) |-> (rd_data == '0));

  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_LIVE && evt_rise == '0) |=> ($stable(mask_w) && $stable(pend_w)));
endmodule

// File: tb/sc_irq_mask_ctrl_tb.sv
module sc_irq_mask_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [12:0] evt_lvl = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sc_irq_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_lvl(evt_lvl), .irq(irq)
  );

  // reference model, written from the requirement list
  logic [12:0] m_mask = '0, m_pend = '0, m_prev = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask <= '0; m_pend <= '0; m_prev <= '0;
    end else begin
      m_prev <= evt_lvl;
      if (wr_en && wr_addr == 3'd0) m_mask <= m_mask | wr_data[12:0];
      if (wr_en && wr_addr == 3'd1) m_mask <= m_mask & ~wr_data[12:0];
      m_pend <= (wr_en && wr_addr == 3'd3 ? (m_pend & ~wr_data[12:0]) : m_pend)
                | (evt_lvl & ~m_prev);
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd2:    return {19'd0, m_mask};
      3'd3:    return {19'd0, m_pend};
      3'd4:    return {19'd0, evt_lvl[4], evt_lvl[3], 1'b0, evt_lvl[1], evt_lvl[0]} & 32'h1B;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int i = 0; i < 13; i++) r = r | (m_pend[i] & m_mask[i]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd_chk(3'd2, 32'h0, "R9 mask after reset");
    rd_chk(3'd3, 32'h0, "R9 pending after reset");
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);

    reg_wr(3'd0, 32'h105);
    rd_chk(3'd2, 32'h105, "R1 enable sets bits");
    rd_chk(3'd0, 32'h0, "R3 enable word reads zero");
    rd_chk(3'd1, 32'h0, "R3 disable word reads zero");
    reg_wr(3'd2, 32'h1FFF);
    rd_chk(3'd2, 32'h105, "R3 mask word is read-only");
    reg_wr(3'd1, 32'h100);
    rd_chk(3'd2, 32'h005, "R2 disable clears bit");

    evt_lvl = 13'h100;
    idle();
    rd_chk(3'd3, 32'h100, "R4 masked event latches");
    chk("R7 masked pending gives no irq", {31'd0, irq}, 32'd0);
    reg_wr(3'd0, 32'h100);
    chk("R7 enabling pending raises irq", {31'd0, irq}, 32'd1);

    reg_wr(3'd3, 32'h100);
    rd_chk(3'd3, 32'h0, "R5 write-one clears pending");
    chk("R7 irq drops after clear", {31'd0, irq}, 32'd0);
    idle();
    rd_chk(3'd3, 32'h0, "R10 held level does not re-set");
    evt_lvl = 13'h000;
    idle();
    evt_lvl = 13'h100;
    idle();
    rd_chk(3'd3, 32'h100, "R10 new rise sets again");
    reg_wr(3'd3, 32'h100);

    @(negedge clk);
    evt_lvl = 13'h140; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h040;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(3'd3, 32'h040, "R6 rise beats simultaneous clear");
    reg_wr(3'd3, 32'h1FFF);
    rd_chk(3'd3, 32'h0, "R5 clear all");

    evt_lvl = 13'h1FFF;
    idle();
    rd_chk(3'd3, 32'h1EBF, "R4 spare and data bits latch");
    rd_chk(3'd4, 32'h1B, "R8 live view");
    reg_wr(3'd1, 32'h1FFF);
    rd_chk(3'd4, 32'h1B, "R8 live view ignores mask");
    rd_chk(3'd3, 32'h1EBF, "R4 pending kept with mask off");
    chk("R7 no irq when mask empty", {31'd0, irq}, 32'd0);
    evt_lvl = 13'h0;
    rd_chk(3'd4, 32'h0, "R8 live view follows level");

    reg_wr(3'd6, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'h0, "R11 unmapped write leaves mask");
    rd_chk(3'd3, 32'h1EBF, "R11 unmapped write leaves pending");
    rd_chk(3'd5, 32'h0, "R11 word 5 reads zero");
    rd_chk(3'd6, 32'h0, "R11 word 6 reads zero");
    rd_chk(3'd7, 32'h0, "R11 word 7 reads zero");
    reg_wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'h1FFF, "R1 upper data bits ignored");
    chk("R7 irq with enabled pending", {31'd0, irq}, 32'd1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd_chk(3'd2, 32'h0, "R9 mask after mid-run reset");
    rd_chk(3'd3, 32'h0, "R9 pending after mid-run reset");
    chk("R9 irq after mid-run reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // constrained random against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      rd_addr = 3'($urandom % 8);
      #1;
      chk("R1 R2 R5 R8 random read", rd_data, model_read(rd_addr));
      chk("R7 random irq", {31'd0, irq}, {31'd0, model_irq()});
      wr_en   = ($urandom % 3) != 0;
      wr_addr = 3'($urandom % 8);
      wr_data = $urandom;
      evt_lvl = evt_lvl ^ (13'($urandom) & 13'($urandom) & 13'($urandom));
    end
    @(negedge clk);
    wr_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule